// File: doc/BRIEF.md
# Shared Bus Ownership Semaphore

This block decides which of two masters may drive a shared SMBus controller: the host software, or an embedded microcontroller that watches fans and sensors over the same bus. It holds a single ownership state with three values: nobody, host or microcontroller. A party is granted the bus only while the other one does not hold it. The host reaches the semaphore through one byte-wide control register. Writing a one to the claim bit asks for the bus. Writing a one to the drop bit gives it back. The claim bit reads back as one only while the host holds the bus, so a refused claim reads back as zero. Software then waits about a millisecond and tries again, up to a retry limit that is kept in software.

The microcontroller has its own single-cycle claim and drop strobes and its own grant output. The host grant is also brought out as a signal, so that the bus multiplexer can follow the owner. If both parties claim a free bus in the same cycle, a fixed priority picks the microcontroller. The other bits of the control register are plain storage.

Top module: `smb_own_sema`

## Requirements
- R1: After reset nobody owns the bus. Both grants are 0 and the register reads 0x00.
- R2: When the bus is free and the microcontroller is not claiming it, a host write with bit 4 set gives the host the bus from the next cycle. From then on `host_grant_o` is 1 and bit 4 of the register reads 1.
- R3: A host write with bit 4 set while the microcontroller owns the bus has no effect. Bit 4 reads 0 and `host_grant_o` stays 0.
- R4: A host write with bit 5 set frees the bus held by the host from the next cycle. If bits 4 and 5 are written together, the drop wins and the claim is ignored.
- R5: When the bus is free, a pulse on `mcu_claim_i` gives the microcontroller the bus from the next cycle (`mcu_grant_o` = 1). A pulse on `mcu_drop_i` while it owns the bus frees the bus from the next cycle.
- R6: A microcontroller claim while the host owns the bus has no effect. `mcu_grant_o` stays 0 and the host keeps the bus.
- R7: When both parties claim a free bus in the same cycle, the microcontroller gets the bus and the host claim is dropped.
- R8: The two grants are never 1 at the same time.
- R9: Bits 4 and 5 are command bits and are not stored. Bit 5 always reads 0, and bit 4 shows only the host's ownership. Every other register bit keeps the last value written and reads it back.
- R10: A drop from the party that does not own the bus has no effect. This covers a host write of bit 5 while the microcontroller owns the bus, and `mcu_drop_i` while the host owns it.
- R11: A host write with bit 4 clear and bit 5 clear changes only the stored bits and never the ownership.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_wdata_i | input | 8 | Host write data. Bit 4 claims the bus, bit 5 drops it |
| host_rdata_o | output | 8 | Register read value. Bit 4 is the host grant |
| host_grant_o | output | 1 | Host currently owns the bus |
| mcu_claim_i | input | 1 | Microcontroller claim strobe |
| mcu_drop_i | input | 1 | Microcontroller drop strobe |
| mcu_grant_o | output | 1 | Microcontroller currently owns the bus |

## Verification
The assertions check on every cycle that the two grants never overlap. They also check that a claim made against the current owner never produces a grant on the next cycle, that the owner's drop always frees the bus, and that a tie on a free bus goes to the microcontroller. Other behaviour can only be shown by the bench scenarios, which compare against the reference model on every cycle. That covers the register read-back composition: stored bits next to a live grant bit and a drop bit that always reads zero. It also covers the reset value, and claim/drop sequences in which a drop from a non-owner or a combined claim-and-drop write must leave the state as the model predicts.

// File: rtl/smb_own_sema_pkg.sv
package smb_own_sema_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_HOST = 2'd1,
      OWN_MCU  = 2'd2
   } owner_t;
endpackage

// File: rtl/sema_ctl_reg.sv
module sema_ctl_reg #(
   parameter int REG_W   = 8,
   parameter int CLM_BIT = 4,
   parameter int DRP_BIT = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             host_own_i,
   output logic             claim_o,
   output logic             drop_o,
   output logic [REG_W-1:0] rdata_o
);
   localparam logic [REG_W-1:0] CMD_MASK =
      (REG_W'(1) << CLM_BIT) | (REG_W'(1) << DRP_BIT);

   logic [REG_W-1:0] store_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   store_q <= '0;
      else if (wr_i) store_q <= wdata_i & ~CMD_MASK;
   end

   assign claim_o = wr_i & wdata_i[CLM_BIT];
   assign drop_o  = wr_i & wdata_i[DRP_BIT];

   always_comb begin
      rdata_o          = store_q;
      rdata_o[CLM_BIT] = host_own_i;
   end
endmodule

// File: rtl/sema_arbiter.sv
module sema_arbiter
   import smb_own_sema_pkg::*;
#(
   parameter bit MCU_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic host_claim_i,
   input  logic host_drop_i,
   input  logic mcu_claim_i,
   input  logic mcu_drop_i,
   output logic host_own_o,
   output logic mcu_own_o
);
   owner_t owner_q, owner_d, idle_pick;

   generate
      if (MCU_WINS) begin : g_mcu_first
         always_comb begin
            if (mcu_claim_i)       idle_pick = OWN_MCU;
            else if (host_claim_i) idle_pick = OWN_HOST;
            else                   idle_pick = OWN_NONE;
         end
      end else begin : g_host_first
         always_comb begin
            if (host_claim_i)      idle_pick = OWN_HOST;
            else if (mcu_claim_i)  idle_pick = OWN_MCU;
            else                   idle_pick = OWN_NONE;
         end
      end
   endgenerate

   always_comb begin
      owner_d = owner_q;
      unique case (owner_q)
         OWN_NONE: owner_d = (host_claim_i && host_drop_i && !mcu_claim_i)
                             ? OWN_NONE : idle_pick;
         OWN_HOST: if (host_drop_i) owner_d = OWN_NONE;
         OWN_MCU:  if (mcu_drop_i)  owner_d = OWN_NONE;
         default:  owner_d = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) owner_q <= OWN_NONE;
      else         owner_q <= owner_d;
   end

   assign host_own_o = (owner_q == OWN_HOST);
   assign mcu_own_o  = (owner_q == OWN_MCU);

   // R8
   p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_own_o && mcu_own_o));
   // R3
   p_host_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mcu_own_o && host_claim_i) |=> !host_own_o);
   // R6
   p_mcu_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_own_o && mcu_claim_i) |=> !mcu_own_o);
   // R4
   p_host_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_own_o && host_drop_i) |=> !host_own_o);
   // R5
   p_mcu_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mcu_own_o && mcu_drop_i) |=> !mcu_own_o);
   // R7
   generate
      if (MCU_WINS) begin : g_tie_chk
         p_tie_mcu_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!host_own_o && !mcu_own_o && mcu_claim_i && host_claim_i) |=> mcu_own_o);
      end
   endgenerate
endmodule

// File: rtl/smb_own_sema.sv
module smb_own_sema #(
   parameter int REG_W    = 8,
   parameter int CLM_BIT  = 4,
   parameter int DRP_BIT  = 5,
   parameter bit MCU_WINS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_wr_i,
   input  logic [REG_W-1:0] host_wdata_i,
   output logic [REG_W-1:0] host_rdata_o,
   output logic             host_grant_o,
   input  logic             mcu_claim_i,
   input  logic             mcu_drop_i,
   output logic             mcu_grant_o
);
   generate
      if (CLM_BIT == DRP_BIT) begin : g_bad_bits
         $error("claim and drop bits must differ");
      end
      if (CLM_BIT >= REG_W || DRP_BIT >= REG_W) begin : g_bad_width
         $error("command bits must lie inside the register");
      end
   endgenerate

   logic host_claim, host_drop, host_own, mcu_own;

   sema_ctl_reg #(
      .REG_W  (REG_W),
      .CLM_BIT(CLM_BIT),
      .DRP_BIT(DRP_BIT)
   ) i_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (host_wr_i),
      .wdata_i   (host_wdata_i),
      .host_own_i(host_own),
      .claim_o   (host_claim),
      .drop_o    (host_drop),
      .rdata_o   (host_rdata_o)
   );

   sema_arbiter #(
      .MCU_WINS(MCU_WINS)
   ) i_arb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .host_claim_i(host_claim),
      .host_drop_i (host_drop),
      .mcu_claim_i (mcu_claim_i),
      .mcu_drop_i  (mcu_drop_i),
      .host_own_o  (host_own),
      .mcu_own_o   (mcu_own)
   );

   assign host_grant_o = host_own;
   assign mcu_grant_o  = mcu_own;

   // R9: the drop bit never reads back as one
   p_drop_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_wr_i |=> !host_rdata_o[DRP_BIT]);
endmodule

// File: tb/test_smb_own_sema.sv
`timescale 1ns/1ps
module test_smb_own_sema;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic       hgnt, mgnt, mclaim, mdrop;

   int n_chk  = 0;
   int n_fail = 0;
   int m_owner = 0;     // 0 none, 1 host, 2 mcu
   logic [7:0] m_store = 8'h00;
   bit done = 0;

   always #2.5 clk = ~clk;

   smb_own_sema i_smb_own_sema (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wdata_i(wdata),
      .host_rdata_o(rdata), .host_grant_o(hgnt),
      .mcu_claim_i(mclaim), .mcu_drop_i(mdrop), .mcu_grant_o(mgnt)
   );

   task automatic compare(input string tag);
      logic [7:0] exp_rd;
      exp_rd = m_store | ((m_owner == 1) ? 8'h10 : 8'h00);
      n_chk++;
      if (rdata !== exp_rd || hgnt !== (m_owner == 1) || mgnt !== (m_owner == 2)) begin
         n_fail++;
         $display("FAIL %s: rdata=%h hgnt=%b mgnt=%b expected rdata=%h hgnt=%b mgnt=%b",
                  tag, rdata, hgnt, mgnt, exp_rd, m_owner == 1, m_owner == 2);
      end
   endtask

   // drive at negedge, model updates at the edge, compare at next negedge
   task automatic step(input logic w, input logic [7:0] d, input logic mc,
                       input logic md, input string tag);
      bit hc, hd;
      wr = w; wdata = d; mclaim = mc; mdrop = md;
      hc = w && d[4];
      hd = w && d[5];
      @(posedge clk);
      case (m_owner)
         0: if (mc) m_owner = 2; else if (hc && !hd) m_owner = 1;
         1: if (hd) m_owner = 0;
         2: if (md) m_owner = 0;
         default: m_owner = 0;
      endcase
      if (w) m_store = d & 8'hCF;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      rst_n = 1'b0; wr = 0; wdata = 0; mclaim = 0; mdrop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset state");
      step(0, 8'h00, 0, 0, "R1 idle after reset");
      step(1, 8'h10, 0, 0, "R2 host claim on free bus");
      step(1, 8'h10, 0, 0, "R2 host reclaim keeps bus");
      step(0, 8'h00, 1, 0, "R6 mcu claim while host owns");
      step(0, 8'h00, 0, 1, "R10 mcu drop while host owns");
      step(1, 8'hC3, 0, 0, "R11 plain write keeps host ownership");
      step(1, 8'h20, 0, 0, "R4 host drop");
      step(0, 8'h00, 1, 0, "R5 mcu claim on free bus");
      step(1, 8'h10, 0, 0, "R3 host claim while mcu owns");
      step(1, 8'h20, 0, 0, "R10 host drop while mcu owns");
      step(1, 8'hFF, 0, 0, "R9 command bits not stored");
      step(0, 8'h00, 0, 1, "R5 mcu drop");
      step(1, 8'h10, 1, 0, "R7 simultaneous claim mcu wins");
      step(0, 8'h00, 0, 1, "R5 mcu drop after tie");
      step(1, 8'h30, 0, 0, "R4 claim and drop together on free bus");
      step(1, 8'h10, 0, 0, "R2 claim again");
      step(1, 8'h30, 0, 0, "R4 claim and drop together releases");
      step(1, 8'hA5, 0, 0, "R9 store pattern A5");
      step(1, 8'h5A, 0, 0, "R9 store pattern 5A");
      step(1, 8'h00, 0, 0, "R11 zero write no ownership change");
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step(r[0] | r[1], 8'($urandom), r[2] & r[3], r[4] & r[5], "R8 random sequence");
      end
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule